// File: doc/BRIEF.md
# Endpoint Self-Test Command Engine

This block sits behind the base register window of a bus endpoint and gives the host a way to exercise its own buffers. The host programs buffer addresses, a transfer length and interrupt settings through a word-wide register port, then writes a one-hot command. The engine reads words from a host buffer and sums them, fills a host buffer with an incrementing pattern, or copies one buffer to another. It also raises an interrupt on request. The engine reaches memory through a simple master port with request, grant and error signals.

Each finished operation leaves a success or fail flag for its own kind in a status register, together with flags for a bad source or destination address. Every finished command, including a failed one, ends in a single-cycle interrupt request. The host clears status flags one by one by writing ones to them. A scratch register lets the host check that the register window itself works. The host-side buffer window and all widths are parameters.

Top module: `ep_selftest_engine`

## Requirements
- R1: The register word offsets are: 0 scratch, 1 command, 2 status, 3 source address, 4 destination address, 5 size in words, 6 interrupt kind, 7 interrupt number, 8 checksum (read only). A read of the scratch register returns exactly the last value written to it.
- R2: Command bits are: bit0 legacy interrupt, bit1 MSI, bit2 MSI-X, bit3 read, bit4 write, bit5 copy. When several bits are written together, only the lowest set bit is carried out. The command register reads back zero once the engine has taken the command.
- R3: A command write that arrives while a command is pending or running is ignored. It produces no extra completion, no extra interrupt and no memory access.
- R4: A read command fetches `size` words starting at the source address, at consecutive word addresses. It leaves their 32-bit wrapping sum in the checksum register and sets status bit0.
- R5: A write command stores the word scratch+i at destination address +4*i for i from 0 to size-1, and sets status bit2.
- R6: A copy command writes each source word to the same offset in the destination buffer, and sets status bit4.
- R7: A size of zero with a valid address completes with the success bit of that operation and performs no memory access.
- R8: An address is valid when it is word-aligned, lies inside [WIN_BASE, WIN_LIMIT), and the whole buffer of `size` words ends at or below WIN_LIMIT. An invalid address sets status bit7 (source) or bit8 (destination) and the fail bit of the operation (bit1 read, bit3 write, bit5 copy). No memory access takes place.
- R9: An error response on a granted memory access aborts the operation, sets its fail bit and still raises the completion interrupt.
- R10: Every completed command pulses irq_req for exactly one cycle and sets status bit6. Interrupt commands report the kind given by their bit (0 legacy, 1 MSI, 2 MSI-X). Read, write and copy report the interrupt kind register. Both report the interrupt number register.
- R11: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. Status bits become set only when a command completes. After reset the status register reads zero.
- R12: Once mem_req is raised it stays high, with address, write enable and write data unchanged, until mem_gnt is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data for reg_addr, combinational |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a store, 0 for a fetch |
| mem_addr | output | AW | Byte address of the word accessed |
| mem_wdata | output | DW | Store data |
| mem_gnt | input | 1 | Access accepted this cycle; rdata and err are valid with it |
| mem_rdata | input | DW | Fetched word |
| mem_err | input | 1 | Error response for the granted access |
| irq_req | output | 1 | One-cycle interrupt request at completion |
| irq_kind | output | 2 | Interrupt kind: 0 legacy, 1 MSI, 2 MSI-X |
| irq_num | output | NUMW | Interrupt number |

## Verification
A wrong sequencing state shows up at the memory port within a cycle or two. It appears as an access at an address outside the buffer, an access after an address check failed, a request that drops before its grant, or an access count that differs from the size register. A wrong status or interrupt state shows on the first status read after the completion pulse: a wrong flag, a missing flag or a flag set with no completion, or an interrupt kind that does not match the command. A corrupted count, sum or pattern value is seen only when the operation ends, through the checksum register or the words left in the bench's memory model. A command register that fails to ignore writes while busy shows as a second completion pulse within a few dozen cycles.

// File: rtl/ep_st_pkg.sv
package ep_st_pkg;

  localparam int NCMD   = 6;
  localparam int STW    = 9;
  localparam int REG_AW = 4;

  localparam logic [REG_AW-1:0] RA_SCRATCH  = 4'd0;
  localparam logic [REG_AW-1:0] RA_CMD      = 4'd1;
  localparam logic [REG_AW-1:0] RA_STATUS   = 4'd2;
  localparam logic [REG_AW-1:0] RA_SRC      = 4'd3;
  localparam logic [REG_AW-1:0] RA_DST      = 4'd4;
  localparam logic [REG_AW-1:0] RA_SIZE     = 4'd5;
  localparam logic [REG_AW-1:0] RA_IRQ_KIND = 4'd6;
  localparam logic [REG_AW-1:0] RA_IRQ_NUM  = 4'd7;
  localparam logic [REG_AW-1:0] RA_SUM      = 4'd8;

  localparam logic [STW-1:0] M_RD_OK   = 9'h001;
  localparam logic [STW-1:0] M_RD_FAIL = 9'h002;
  localparam logic [STW-1:0] M_WR_OK   = 9'h004;
  localparam logic [STW-1:0] M_WR_FAIL = 9'h008;
  localparam logic [STW-1:0] M_CP_OK   = 9'h010;
  localparam logic [STW-1:0] M_CP_FAIL = 9'h020;
  localparam logic [STW-1:0] M_IRQ     = 9'h040;
  localparam logic [STW-1:0] M_SRC_BAD = 9'h080;
  localparam logic [STW-1:0] M_DST_BAD = 9'h100;

  // Operation code equals the command bit position that selects it.
  typedef enum logic [2:0] {
    OP_LEGACY = 3'd0,
    OP_MSI    = 3'd1,
    OP_MSIX   = 3'd2,
    OP_READ   = 3'd3,
    OP_WRITE  = 3'd4,
    OP_COPY   = 3'd5
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_CHECK = 3'd1,
    S_RD    = 3'd2,
    S_WR    = 3'd3,
    S_DONE  = 3'd4
  } mv_state_e;

  // Lowest set command bit wins.
  function automatic op_e pick_op(input logic [NCMD-1:0] c);
    op_e r;
    r = OP_LEGACY;
    for (int i = NCMD - 1; i >= 0; i--) begin
      if (c[i]) r = op_e'(i[2:0]);
    end
    return r;
  endfunction

  function automatic logic is_data_op(input op_e op);
    return (op == OP_READ) || (op == OP_WRITE) || (op == OP_COPY);
  endfunction

  function automatic logic uses_src(input op_e op);
    return (op == OP_READ) || (op == OP_COPY);
  endfunction

  function automatic logic uses_dst(input op_e op);
    return (op == OP_WRITE) || (op == OP_COPY);
  endfunction

  function automatic logic [STW-1:0] ok_mask(input op_e op);
    case (op)
      OP_READ:  return M_RD_OK;
      OP_WRITE: return M_WR_OK;
      OP_COPY:  return M_CP_OK;
      default:  return '0;
    endcase
  endfunction

  function automatic logic [STW-1:0] fail_mask(input op_e op);
    case (op)
      OP_READ:  return M_RD_FAIL;
      OP_WRITE: return M_WR_FAIL;
      OP_COPY:  return M_CP_FAIL;
      default:  return '0;
    endcase
  endfunction

endpackage

// File: rtl/ep_st_addr_chk.sv
module ep_st_addr_chk #(
  parameter int AW = 32,
  parameter int CNT_W = 16,
  parameter int LSB = 2,
  parameter logic [AW-1:0] WIN_BASE = 'h1000,
  parameter logic [AW-1:0] WIN_LIMIT = 'h2000
) (
  input  logic [AW-1:0]    addr,
  input  logic [CNT_W-1:0] words,
  output logic             ok
);
  localparam int EW = AW + CNT_W + LSB + 1;

  function automatic logic [EW-1:0] buf_end(input logic [AW-1:0] a,
                                             input logic [CNT_W-1:0] n);
    return EW'(a) + (EW'(n) << LSB);
  endfunction

  logic aligned, start_in, end_in;

  assign aligned  = (addr[LSB-1:0] == '0);
  assign start_in = (addr >= WIN_BASE) && (addr < WIN_LIMIT);
  assign end_in   = buf_end(addr, words) <= EW'(WIN_LIMIT);
  assign ok       = aligned && start_in && end_in;

endmodule

// File: rtl/ep_st_regs.sv
module ep_st_regs
  import ep_st_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 32,
  parameter int CNT_W = 16,
  parameter int NUMW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              eng_idle,
  input  logic              done_evt,
  input  logic [STW-1:0]    done_set,
  input  logic [DW-1:0]     sum_val,
  output logic              start,
  output op_e               start_op,
  output logic [AW-1:0]     src,
  output logic [AW-1:0]     dst,
  output logic [CNT_W-1:0]  size,
  output logic [1:0]        irq_type,
  output logic [NUMW-1:0]   irq_number,
  output logic [DW-1:0]     scratch,
  output logic [STW-1:0]    status
);
  logic [NCMD-1:0] cmd_q;
  logic            cmd_take;
  logic [STW-1:0]  clr_mask, set_mask;

  function automatic logic hit(input logic wr, input logic [REG_AW-1:0] a,
                               input logic [REG_AW-1:0] target);
    return wr && (a == target);
  endfunction

  // A command is taken only when nothing is pending and the engine is idle.
  assign cmd_take = hit(reg_wr, reg_addr, RA_CMD) && eng_idle && (cmd_q == '0);
  assign start    = eng_idle && (cmd_q != '0);
  assign start_op = pick_op(cmd_q);

  assign clr_mask = hit(reg_wr, reg_addr, RA_STATUS) ? reg_wdata[STW-1:0] : '0;
  assign set_mask = done_evt ? done_set : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q      <= '0;
      scratch    <= '0;
      src        <= '0;
      dst        <= '0;
      size       <= '0;
      irq_type   <= '0;
      irq_number <= '0;
      status     <= '0;
    end else begin
      if (hit(reg_wr, reg_addr, RA_SCRATCH))  scratch    <= reg_wdata;
      if (hit(reg_wr, reg_addr, RA_SRC))      src        <= reg_wdata[AW-1:0];
      if (hit(reg_wr, reg_addr, RA_DST))      dst        <= reg_wdata[AW-1:0];
      if (hit(reg_wr, reg_addr, RA_SIZE))     size       <= reg_wdata[CNT_W-1:0];
      if (hit(reg_wr, reg_addr, RA_IRQ_KIND)) irq_type   <= reg_wdata[1:0];
      if (hit(reg_wr, reg_addr, RA_IRQ_NUM))  irq_number <= reg_wdata[NUMW-1:0];
      if (start)         cmd_q <= '0;
      else if (cmd_take) cmd_q <= reg_wdata[NCMD-1:0];
      // Set wins over a clear in the same cycle.
      status <= (status & ~clr_mask) | set_mask;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_SCRATCH:  reg_rdata = scratch;
      RA_CMD:      reg_rdata[NCMD-1:0] = cmd_q;
      RA_STATUS:   reg_rdata[STW-1:0] = status;
      RA_SRC:      reg_rdata[AW-1:0] = src;
      RA_DST:      reg_rdata[AW-1:0] = dst;
      RA_SIZE:     reg_rdata[CNT_W-1:0] = size;
      RA_IRQ_KIND: reg_rdata[1:0] = irq_type;
      RA_IRQ_NUM:  reg_rdata[NUMW-1:0] = irq_number;
      RA_SUM:      reg_rdata = sum_val;
      default:     reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/ep_st_mover.sv
module ep_st_mover
  import ep_st_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 32,
  parameter int CNT_W = 16,
  parameter int NUMW = 12,
  parameter int LSB = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  op_e              start_op,
  input  logic [AW-1:0]    src,
  input  logic [AW-1:0]    dst,
  input  logic [CNT_W-1:0] size,
  input  logic [DW-1:0]    seed,
  input  logic [1:0]       irq_type,
  input  logic [NUMW-1:0]  irq_number,
  output logic [AW-1:0]    lat_src,
  output logic [AW-1:0]    lat_dst,
  output logic [CNT_W-1:0] lat_size,
  input  logic             src_ok,
  input  logic             dst_ok,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic             mem_gnt,
  input  logic [DW-1:0]    mem_rdata,
  input  logic             mem_err,
  output logic             idle,
  output logic             done_evt,
  output logic [STW-1:0]   done_set,
  output logic [DW-1:0]    sum,
  output logic             irq_req,
  output logic [1:0]       irq_kind,
  output logic [NUMW-1:0]  irq_num
);
  mv_state_e        state;
  op_e              op_q;
  logic [AW-1:0]    src_q, dst_q;
  logic [CNT_W-1:0] size_q, cnt_q;
  logic [DW-1:0]    seed_q, data_q, sum_q;
  logic [STW-1:0]   set_q;
  logic [1:0]       kind_q;
  logic [NUMW-1:0]  num_q;
  logic [2:0]       op_bits;

  logic bad_s, bad_d, last_word, in_rd, in_wr;

  function automatic logic [AW-1:0] word_addr(input logic [AW-1:0] base,
                                               input logic [CNT_W-1:0] idx);
    return base + (AW'(idx) << LSB);
  endfunction

  function automatic logic [DW-1:0] pattern(input logic [DW-1:0] s,
                                             input logic [CNT_W-1:0] idx);
    return s + DW'(idx);
  endfunction

  assign op_bits   = start_op;
  assign bad_s     = uses_src(op_q) && !src_ok;
  assign bad_d     = uses_dst(op_q) && !dst_ok;
  assign last_word = (cnt_q == size_q - CNT_W'(1));
  assign in_rd     = (state == S_RD);
  assign in_wr     = (state == S_WR);

  assign lat_src  = src_q;
  assign lat_dst  = dst_q;
  assign lat_size = size_q;

  assign mem_req   = in_rd || in_wr;
  assign mem_we    = in_wr;
  assign mem_addr  = in_rd ? word_addr(src_q, cnt_q) : word_addr(dst_q, cnt_q);
  assign mem_wdata = (op_q == OP_COPY) ? data_q : pattern(seed_q, cnt_q);

  assign idle     = (state == S_IDLE);
  assign done_evt = (state == S_DONE);
  assign irq_req  = done_evt;
  assign done_set = set_q;
  assign sum      = sum_q;
  assign irq_kind = kind_q;
  assign irq_num  = num_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      op_q   <= OP_LEGACY;
      src_q  <= '0;
      dst_q  <= '0;
      size_q <= '0;
      cnt_q  <= '0;
      seed_q <= '0;
      data_q <= '0;
      sum_q  <= '0;
      set_q  <= '0;
      kind_q <= '0;
      num_q  <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (start) begin
            op_q   <= start_op;
            src_q  <= src;
            dst_q  <= dst;
            size_q <= size;
            seed_q <= seed;
            num_q  <= irq_number;
            cnt_q  <= '0;
            if (is_data_op(start_op)) begin
              kind_q <= irq_type;
              sum_q  <= '0;
              set_q  <= '0;
              state  <= S_CHECK;
            end else begin
              kind_q <= op_bits[1:0];
              set_q  <= M_IRQ;
              state  <= S_DONE;
            end
          end
        end
        S_CHECK: begin
          if (bad_s || bad_d) begin
            set_q <= fail_mask(op_q) | M_IRQ | (bad_s ? M_SRC_BAD : '0)
                     | (bad_d ? M_DST_BAD : '0);
            state <= S_DONE;
          end else if (size_q == '0) begin
            set_q <= ok_mask(op_q) | M_IRQ;
            state <= S_DONE;
          end else begin
            state <= uses_src(op_q) ? S_RD : S_WR;
          end
        end
        S_RD: begin
          if (mem_gnt) begin
            if (mem_err) begin
              set_q <= fail_mask(op_q) | M_IRQ;
              state <= S_DONE;
            end else begin
              data_q <= mem_rdata;
              if (op_q == OP_READ) begin
                sum_q <= sum_q + mem_rdata;
                cnt_q <= cnt_q + CNT_W'(1);
                if (last_word) begin
                  set_q <= ok_mask(op_q) | M_IRQ;
                  state <= S_DONE;
                end
              end else begin
                state <= S_WR;
              end
            end
          end
        end
        S_WR: begin
          if (mem_gnt) begin
            if (mem_err) begin
              set_q <= fail_mask(op_q) | M_IRQ;
              state <= S_DONE;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
              if (last_word) begin
                set_q <= ok_mask(op_q) | M_IRQ;
                state <= S_DONE;
              end else if (op_q == OP_COPY) begin
                state <= S_RD;
              end
            end
          end
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ep_selftest_engine.sv
module ep_selftest_engine
  import ep_st_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 32,
  parameter int CNT_W = 16,
  parameter int NUMW = 12,
  parameter logic [AW-1:0] WIN_BASE = 'h1000,
  parameter logic [AW-1:0] WIN_LIMIT = 'h2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic              mem_gnt,
  input  logic [DW-1:0]     mem_rdata,
  input  logic              mem_err,
  output logic              irq_req,
  output logic [1:0]        irq_kind,
  output logic [NUMW-1:0]   irq_num
);
  localparam int LSB = $clog2(DW / 8);
  localparam int NCHK = 2;

  // Named internal events, observed by the bound checker.
  logic             eng_idle;
  logic             start_evt;
  logic             done_evt;
  logic [STW-1:0]   done_set;
  logic [STW-1:0]   status_w;
  op_e              start_op;
  logic [AW-1:0]    src_w, dst_w, lat_src, lat_dst;
  logic [CNT_W-1:0] size_w, lat_size;
  logic [1:0]       irq_type_w;
  logic [NUMW-1:0]  irq_number_w;
  logic [DW-1:0]    scratch_w, sum_w;
  logic [AW-1:0]    chk_addr [NCHK];
  logic [NCHK-1:0]  chk_ok;

  ep_st_regs #(.DW(DW), .AW(AW), .CNT_W(CNT_W), .NUMW(NUMW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .eng_idle   (eng_idle),
    .done_evt   (done_evt),
    .done_set   (done_set),
    .sum_val    (sum_w),
    .start      (start_evt),
    .start_op   (start_op),
    .src        (src_w),
    .dst        (dst_w),
    .size       (size_w),
    .irq_type   (irq_type_w),
    .irq_number (irq_number_w),
    .scratch    (scratch_w),
    .status     (status_w)
  );

  assign chk_addr[0] = lat_src;
  assign chk_addr[1] = lat_dst;

  for (genvar g = 0; g < NCHK; g++) begin : g_chk
    ep_st_addr_chk #(
      .AW(AW), .CNT_W(CNT_W), .LSB(LSB),
      .WIN_BASE(WIN_BASE), .WIN_LIMIT(WIN_LIMIT)
    ) u_chk (
      .addr  (chk_addr[g]),
      .words (lat_size),
      .ok    (chk_ok[g])
    );
  end

  ep_st_mover #(.DW(DW), .AW(AW), .CNT_W(CNT_W), .NUMW(NUMW), .LSB(LSB)) u_mover (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start_evt),
    .start_op   (start_op),
    .src        (src_w),
    .dst        (dst_w),
    .size       (size_w),
    .seed       (scratch_w),
    .irq_type   (irq_type_w),
    .irq_number (irq_number_w),
    .lat_src    (lat_src),
    .lat_dst    (lat_dst),
    .lat_size   (lat_size),
    .src_ok     (chk_ok[0]),
    .dst_ok     (chk_ok[1]),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_gnt    (mem_gnt),
    .mem_rdata  (mem_rdata),
    .mem_err    (mem_err),
    .idle       (eng_idle),
    .done_evt   (done_evt),
    .done_set   (done_set),
    .sum        (sum_w),
    .irq_req    (irq_req),
    .irq_kind   (irq_kind),
    .irq_num    (irq_num)
  );

endmodule

// File: rtl/ep_selftest_checker.sv
module ep_selftest_checker #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int STW = 9,
  parameter int RAW = 4,
  parameter int LSB = 2,
  parameter logic [RAW-1:0] CMD_OFS = 4'd1,
  parameter logic [AW-1:0] WIN_BASE = 'h1000,
  parameter logic [AW-1:0] WIN_LIMIT = 'h2000
) (
  input logic           clk,
  input logic           rst_n,
  input logic           reg_wr,
  input logic [RAW-1:0] reg_addr,
  input logic           mem_req,
  input logic           mem_gnt,
  input logic           mem_we,
  input logic [AW-1:0]  mem_addr,
  input logic [DW-1:0]  mem_wdata,
  input logic           irq_req,
  input logic           eng_idle,
  input logic           start_evt,
  input logic           done_evt,
  input logic [STW-1:0] status_q
);

  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata)));

  assert_irq_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |=> !irq_req);

  assert_addr_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ((mem_addr[LSB-1:0] == '0) && (mem_addr >= WIN_BASE)
                 && (mem_addr < WIN_LIMIT)));

  assert_status_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & ~$past(status_q)) != '0) |-> $past(done_evt));

  assert_busy_ignore_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_addr == CMD_OFS) && !eng_idle) |=> !start_evt);

  assert_quiet_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> !mem_req);

endmodule

bind ep_selftest_engine ep_selftest_checker #(
  .AW(AW), .DW(DW), .STW(ep_st_pkg::STW), .RAW(ep_st_pkg::REG_AW),
  .LSB(LSB), .CMD_OFS(ep_st_pkg::RA_CMD),
  .WIN_BASE(WIN_BASE), .WIN_LIMIT(WIN_LIMIT)
) u_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .mem_req   (mem_req),
  .mem_gnt   (mem_gnt),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .irq_req   (irq_req),
  .eng_idle  (eng_idle),
  .start_evt (start_evt),
  .done_evt  (done_evt),
  .status_q  (status_w)
);

// File: tb/ep_selftest_engine_bench.sv
module ep_selftest_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h1000;
  localparam int MEMW = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we, mem_gnt, mem_err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        irq_req;
  logic [1:0]  irq_kind;
  logic [11:0] irq_num;

  int checks = 0;
  int failures = 0;

  logic [31:0] mem [MEMW];
  int          lat_cfg = 0;
  int          lat_cnt = 0;
  logic        err_on = 1'b0;
  logic [31:0] err_addr = '0;
  int          acc_cnt = 0;
  int          hold_viol = 0;
  logic        hold_pend = 1'b0;
  logic [31:0] hold_addr = '0;
  logic [9:0]  didx;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ep_selftest_engine u_ep_selftest_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .mem_err(mem_err),
    .irq_req(irq_req), .irq_kind(irq_kind), .irq_num(irq_num)
  );

  function automatic logic [31:0] init_word(input int i);
    return 32'h1357_0000 + 32'(i) * 32'h0001_0203;
  endfunction

  function automatic int widx(input logic [31:0] a);
    return int'((a - BASE) >> 2);
  endfunction

  // Memory model: grant after lat_cfg waiting cycles, optional error at one address.
  assign didx      = 10'((mem_addr - BASE) >> 2);
  assign mem_gnt   = mem_req && (lat_cnt >= lat_cfg);
  assign mem_rdata = mem[didx];
  assign mem_err   = mem_gnt && err_on && (mem_addr == err_addr);

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MEMW; i++) mem[i] <= init_word(i);
      lat_cnt <= 0;
    end else begin
      if (!mem_req || mem_gnt) lat_cnt <= 0;
      else lat_cnt <= lat_cnt + 1;
      if (mem_gnt) acc_cnt <= acc_cnt + 1;
      if (mem_gnt && mem_we && !mem_err) mem[didx] <= mem_wdata;
      if (hold_pend && (!mem_req || mem_addr != hold_addr)) hold_viol <= hold_viol + 1;
      hold_pend <= mem_req && !mem_gnt;
      hold_addr <= mem_addr;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_irq(output logic got, output logic [1:0] k, output logic [11:0] n);
    got = 1'b0; k = '0; n = '0;
    for (int c = 0; c < 2000 && !got; c++) begin
      @(negedge clk);
      if (irq_req) begin
        got = 1'b1; k = irq_kind; n = irq_num;
      end
    end
    @(negedge clk);
  endtask

  task automatic setup(input logic [31:0] s, input logic [31:0] d, input logic [31:0] n);
    reg_write(4'd3, s);
    reg_write(4'd4, d);
    reg_write(4'd5, n);
    reg_write(4'd2, 32'h1FF);
  endtask

  task automatic test_reset();
    logic [31:0] v;
    reg_read(4'd2, v);  check("R11 status after reset", v, 32'h0);
    reg_read(4'd1, v);  check("R2 command after reset", v, 32'h0);
    check("R10 irq_req after reset", {31'b0, irq_req}, 32'h0);
    check("R12 mem_req after reset", {31'b0, mem_req}, 32'h0);
  endtask

  task automatic test_scratch();
    logic [31:0] v;
    reg_write(4'd0, 32'hDEAD_BEEF);
    reg_read(4'd0, v);  check("R1 scratch pattern A", v, 32'hDEAD_BEEF);
    reg_write(4'd0, 32'h0F1E_2D3C);
    reg_read(4'd0, v);  check("R1 scratch pattern B", v, 32'h0F1E_2D3C);
  endtask

  task automatic test_irq_cmd();
    logic got; logic [1:0] k; logic [11:0] n; logic [31:0] v;
    reg_write(4'd7, 32'd5);
    reg_write(4'd2, 32'h1FF);
    reg_write(4'd1, 32'h06);
    wait_irq(got, k, n);
    check("R10 irq command completes", {31'b0, got}, 32'h1);
    check("R2 lowest irq bit gives MSI kind", {30'b0, k}, 32'd1);
    check("R10 irq number", {20'b0, n}, 32'd5);
    reg_read(4'd2, v);  check("R10 irq-only status", v, 32'h040);
    reg_read(4'd1, v);  check("R2 command cleared after accept", v, 32'h0);
  endtask

  task automatic test_read();
    logic got; logic [1:0] k; logic [11:0] n; logic [31:0] v, exp_sum;
    int a0;
    exp_sum = '0;
    for (int i = 0; i < 8; i++) exp_sum += mem[i];
    lat_cfg = 2;
    reg_write(4'd6, 32'd2);
    reg_write(4'd7, 32'd7);
    setup(BASE, BASE, 32'd8);
    a0 = acc_cnt;
    reg_write(4'd1, 32'h08);
    wait_irq(got, k, n);
    check("R4 read completes", {31'b0, got}, 32'h1);
    check("R10 read irq kind from register", {30'b0, k}, 32'd2);
    check("R10 read irq number", {20'b0, n}, 32'd7);
    reg_read(4'd8, v);  check("R4 checksum", v, exp_sum);
    reg_read(4'd2, v);  check("R4 read status", v, 32'h041);
    check("R4 read access count", 32'(acc_cnt - a0), 32'd8);
    lat_cfg = 0;
  endtask

  task automatic test_write();
    logic got; logic [1:0] k; logic [11:0] n; logic [31:0] v;
    int bad;
    reg_write(4'd0, 32'h0000_0100);
    setup(BASE, BASE + 32'h400, 32'd5);
    reg_write(4'd1, 32'h10);
    wait_irq(got, k, n);
    reg_read(4'd2, v);  check("R5 write status", v, 32'h044);
    bad = 0;
    for (int i = 0; i < 5; i++) if (mem[widx(BASE + 32'h400) + i] !== 32'h100 + 32'(i)) bad++;
    check("R5 pattern words mismatching", 32'(bad), 32'd0);
    check("R5 word after buffer untouched", mem[widx(BASE + 32'h400) + 5],
          init_word(widx(BASE + 32'h400) + 5));
  endtask

  task automatic test_copy();
    logic got; logic [1:0] k; logic [11:0] n; logic [31:0] v;
    int bad;
    lat_cfg = 1;
    setup(BASE + 32'h40, BASE + 32'h800, 32'd6);
    reg_write(4'd1, 32'h20);
    wait_irq(got, k, n);
    reg_read(4'd2, v);  check("R6 copy status", v, 32'h050);
    bad = 0;
    for (int i = 0; i < 6; i++)
      if (mem[widx(BASE + 32'h800) + i] !== init_word(widx(BASE + 32'h40) + i)) bad++;
    check("R6 copied words mismatching", 32'(bad), 32'd0);
    lat_cfg = 0;
  endtask

  task automatic test_priority();
    logic got; logic [1:0] k; logic [11:0] n; logic [31:0] v;
    setup(BASE, BASE + 32'hC00, 32'd2);
    reg_write(4'd1, 32'h18);
    wait_irq(got, k, n);
    reg_read(4'd2, v);  check("R2 read chosen over write", v, 32'h041);
    check("R2 write bit not carried out", mem[widx(BASE + 32'hC00)],
          init_word(widx(BASE + 32'hC00)));
  endtask

  task automatic test_busy();
    logic got; logic [1:0] k; logic [11:0] n; logic [31:0] v;
    int extra;
    lat_cfg = 3;
    setup(BASE, BASE + 32'hD00, 32'd4);
    reg_write(4'd1, 32'h08);
    reg_write(4'd1, 32'h10);
    repeat (2) @(negedge clk);
    reg_write(4'd1, 32'h10);
    wait_irq(got, k, n);
    extra = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (irq_req) extra++;
    end
    check("R3 no extra completion", 32'(extra), 32'd0);
    reg_read(4'd2, v);  check("R3 only read reported", v, 32'h041);
    check("R3 ignored write left memory", mem[widx(BASE + 32'hD00)],
          init_word(widx(BASE + 32'hD00)));
    lat_cfg = 0;
  endtask

  task automatic test_zero();
    logic got; logic [1:0] k; logic [11:0] n; logic [31:0] v;
    int a0;
    setup(BASE, BASE + 32'hE00, 32'd0);
    a0 = acc_cnt;
    reg_write(4'd1, 32'h10);
    wait_irq(got, k, n);
    check("R7 zero size completes", {31'b0, got}, 32'h1);
    reg_read(4'd2, v);  check("R7 zero size status", v, 32'h044);
    check("R7 zero size no access", 32'(acc_cnt - a0), 32'd0);
  endtask

  task automatic test_invalid();
    logic got; logic [1:0] k; logic [11:0] n; logic [31:0] v;
    int a0;
    a0 = acc_cnt;
    setup(BASE, BASE + 32'h2, 32'd2);
    reg_write(4'd1, 32'h10);
    wait_irq(got, k, n);
    reg_read(4'd2, v);  check("R8 misaligned destination", v, 32'h148);
    setup(32'h3000, BASE + 32'h900, 32'd2);
    reg_write(4'd1, 32'h20);
    wait_irq(got, k, n);
    check("R8 invalid copy still interrupts", {31'b0, got}, 32'h1);
    reg_read(4'd2, v);  check("R8 source outside window", v, 32'h0E0);
    setup(BASE + 32'hFF8, BASE, 32'd4);
    reg_write(4'd1, 32'h08);
    wait_irq(got, k, n);
    reg_read(4'd2, v);  check("R8 buffer overruns window end", v, 32'h0C2);
    check("R8 no access on invalid address", 32'(acc_cnt - a0), 32'd0);
  endtask

  task automatic test_error();
    logic got; logic [1:0] k; logic [11:0] n; logic [31:0] v;
    int a0;
    err_on = 1'b1; err_addr = BASE + 32'h108;
    setup(BASE + 32'h100, BASE, 32'd4);
    a0 = acc_cnt;
    reg_write(4'd1, 32'h08);
    wait_irq(got, k, n);
    check("R9 error still interrupts", {31'b0, got}, 32'h1);
    reg_read(4'd2, v);  check("R9 read fail status", v, 32'h042);
    check("R9 aborted after error", 32'(acc_cnt - a0), 32'd3);
    err_on = 1'b0;
  endtask

  task automatic test_w1c();
    logic [31:0] v;
    reg_write(4'd2, 32'h040);
    reg_read(4'd2, v);  check("R11 clear only bit6", v, 32'h002);
    reg_write(4'd2, 32'h000);
    reg_read(4'd2, v);  check("R11 zero write keeps bits", v, 32'h002);
    reg_write(4'd2, 32'h002);
    reg_read(4'd2, v);  check("R11 clear last bit", v, 32'h000);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_scratch();
    test_irq_cmd();
    test_read();
    test_write();
    test_copy();
    test_priority();
    test_busy();
    test_zero();
    test_invalid();
    test_error();
    test_w1c();
    check("R12 request held until grant", 32'(hold_viol), 32'd0);
    summary();
  end

endmodule